// File: doc/BRIEF.md
# Low-Power Mode Controller for a 1M x 16 Pseudo-Static RAM

This block is the control side of a 1M x 16 self-refreshing RAM. It follows the device through power-up, normal operation and two sleep flavours. All pins are sampled as synchronous inputs on the block clock. Elapsed time comes from a one-cycle microsecond tick supplied from outside.

Software programs the sleep behaviour with an ordinary write cycle issued while the sleep pin (`zz_n`) is low. The write carries its settings on the low address lines, and the data bus plays no part. The captured value sits in a staging copy and becomes the live setting only when `zz_n` rises again.

When `zz_n` falls and no register write starts within one microsecond, the device enters one of two modes, chosen by the live setting. One is a self-refresh sleep that keeps the contents. The other is a deep power down that loses them. The live setting is also decoded into the address window that stays refreshed, given as a base and a limit address.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset `pstate` is 0 (power-up wait) with `ready`=0 and `data_valid`=0. The block moves to standby (`pstate`=1) once 150 ticks have been counted while `cs_n` and `zz_n` are both high. A low on either pin restarts that count from zero.
- R2: Once out of power-up, with `zz_n` high, `pstate` is 2 (active) when `cs_n` is low and at least one of `lb_n`/`ub_n` is low. Otherwise `pstate` is 1 (standby). `ready` is 1 in both of these states and 0 in every other state.
- R3: A write start is the first cycle in which `cs_n`, `we_n` and at least one byte enable are all low. A write start with `zz_n` low in standby, active, entry-wait or register-write state captures `addr[4:0]` into a staging copy, provided `addr[19:5]` is all zero. Any other write start with `zz_n` low is ignored, including one in sleep or deep power down. The staged value changes the window outputs only when `zz_n` next rises.
- R4: The mode register fields are:
  - bit 4: 0 arms deep power down, 1 disables it.
  - bit 3: 0 selects partial refresh, 1 selects reduced memory size.
  - bit 2: 0 selects the bottom half, 1 the top half.
  - bits 1:0: 00 full array, 01 reserved and decoded as full, 10 one half, 11 one quarter.
  - The reset value is 10000b.
- R5: The window is:
  - full array: `win_base`=00000h, `win_limit`=FFFFFh.
  - half bottom: 00000h to 7FFFFh.
  - half top: 80000h to FFFFFh.
  - quarter bottom: 00000h to 3FFFFh.
  - quarter top: C0000h to FFFFFh.
- R6: A fall of `zz_n` in standby or active state moves the block to `pstate` 3 (entry wait).
  - A capturing write start before one tick has elapsed moves it to `pstate` 4 (register write).
  - Otherwise, after one tick, it goes to `pstate` 5 (sleep) if bit 4 is 1, or to `pstate` 6 (deep power down) if bit 4 is 0.
  - `zz_n` rising during the entry wait returns the block to standby or active.
- R7: Sleep and deep power down are left only when `zz_n` is high and at least 10 ticks have been counted since the state was entered.
- R8: Leaving deep power down enters `pstate` 7 (recovery), with `ready`=0 and `data_valid`=0. After 150 ticks the block returns to standby or active.
- R9: A rise of `zz_n` with nothing staged resets the register to its default when bit 3 is 0. When bit 3 is 1, the rise keeps bits 3:0 and forces bit 4 to 1.
- R10: `rsvd_err` is high for exactly the one cycle after a capture whose `addr[1:0]` is 01.
- R11: `data_valid` is cleared by reset and on entry to deep power down. It is set by a write start with `zz_n` high in standby or active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| zz_n | input | 1 | Sleep request pin, active low |
| addr | input | 20 | Word address; bits 4:0 carry mode settings |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| pstate | output | 3 | Power state code (see R1, R2, R6, R8) |
| ready | output | 1 | Device accepts accesses |
| data_valid | output | 1 | Array contents are retained |
| win_base | output | 20 | Lowest refreshed address |
| win_limit | output | 20 | Highest refreshed address |
| rsvd_err | output | 1 | Pulse after a reserved area code is written |

## Verification
The hardest situation to reach is a staged value that must not become live until a later rise of `zz_n`. The same applies to a rise with nothing staged, which must restore the defaults, or keep the settings in reduced-size mode. The stimulus loads a setting through the entry-wait path and through a write that coincides with the fall of `zz_n`. It then toggles `zz_n` without a write and watches the window outputs after each edge. A write issued while already asleep is followed by an extra `zz_n` pulse, so that a wrongly staged value would show up in the window.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_STBY   = 3'd1,
    ST_ACT    = 3'd2,
    ST_ZZWAIT = 3'd3,
    ST_REGWR  = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_DPD    = 3'd6,
    ST_RECOV  = 3'd7
  } lpm_state_t;

  typedef struct packed {
    logic       dpd_off;
    logic       rms;
    logic       top;
    logic [1:0] area;
  } lpm_mode_t;

  localparam lpm_mode_t MODE_DEFAULT = '{dpd_off: 1'b1, rms: 1'b0, top: 1'b0, area: 2'b00};

  // Settings that survive a wake-up when nothing new was staged.
  function automatic lpm_mode_t wake_mode(lpm_mode_t m);
    lpm_mode_t r;
    r = m;
    r.dpd_off = 1'b1;
    return m.rms ? r : MODE_DEFAULT;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (clr)                     count <= '0;
    else if (tick && count != CMAX)   count <= count + 1'b1;
  end

  // R7: elapsed time never runs backwards unless cleared
  a_r7_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count >= $past(count));

endmodule

// File: rtl/lpm_modereg.sv
module lpm_modereg
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap,
  input  lpm_mode_t cap_val,
  input  logic      zz_rise,
  output lpm_mode_t mode,
  output logic      rsvd_err
);

  lpm_mode_t staged;
  logic      staged_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_DEFAULT;
      staged   <= MODE_DEFAULT;
      staged_v <= 1'b0;
      rsvd_err <= 1'b0;
    end else begin
      rsvd_err <= cap && (cap_val.area == 2'b01);
      if (cap) begin
        staged   <= cap_val;
        staged_v <= 1'b1;
      end else if (zz_rise) begin
        mode     <= staged_v ? staged : wake_mode(mode);
        staged_v <= 1'b0;
      end
    end
  end

  // R3: live setting moves only on a rising sleep pin
  a_r3_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !zz_rise |=> $stable(mode));

  // R10: error pulse always follows a capture
  a_r10_err_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_err |-> $past(cap));

endmodule

// File: rtl/lpm_window.sv
module lpm_window
  import lpm_pkg::*;
#(
  parameter int AW = 20
) (
  input  lpm_mode_t      mode,
  output logic [AW-1:0]  base,
  output logic [AW-1:0]  limit
);

  localparam logic [AW-1:0] FULL_M1 = '1;
  localparam logic [AW-1:0] HALF_M1 = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] QTR_M1  = {2'b00, {(AW-2){1'b1}}};

  function automatic logic [AW-1:0] span_of(logic [1:0] area);
    case (area)
      2'b10:   return HALF_M1;
      2'b11:   return QTR_M1;
      default: return FULL_M1;
    endcase
  endfunction

  logic [AW-1:0] span;

  always_comb begin
    span  = span_of(mode.area);
    base  = mode.top ? (FULL_M1 - span) : '0;
    limit = base + span;
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int AW       = 20,
  parameter int PWRUP_US = 150,
  parameter int WIN_US   = 1,
  parameter int RES_US   = 10,
  parameter int REC_US   = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic          zz_n,
  input  logic [AW-1:0] addr,
  input  logic          us_tick,
  output logic [2:0]    pstate,
  output logic          ready,
  output logic          data_valid,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] win_limit,
  output logic          rsvd_err
);

  localparam int MAXUS = max_of(max_of(PWRUP_US, WIN_US), max_of(RES_US, REC_US));
  localparam int CW    = $clog2(MAXUS + 1);
  localparam logic [CW-1:0] T_PWR = CW'(PWRUP_US);
  localparam logic [CW-1:0] T_WIN = CW'(WIN_US);
  localparam logic [CW-1:0] T_RES = CW'(RES_US);
  localparam logic [CW-1:0] T_REC = CW'(REC_US);

  lpm_state_t    state, state_nx, idle_st;
  lpm_mode_t     mode;
  logic [CW-1:0] tcount;
  logic          wr_prev, zz_prev;
  logic          wr_cond, wr_start, zz_rise, act_cond;
  logic          awake, cap_ok, addr_hi_zero, mode_cap, arr_wr, tmr_clr;

  // Pin events
  assign wr_cond      = !cs_n && !we_n && (!lb_n || !ub_n);
  assign wr_start     = wr_cond && !wr_prev;
  assign zz_rise      = zz_n && !zz_prev;
  assign act_cond     = !cs_n && zz_n && (!lb_n || !ub_n);
  assign awake        = (state == ST_STBY) || (state == ST_ACT);
  assign cap_ok       = awake || (state == ST_ZZWAIT) || (state == ST_REGWR);
  assign addr_hi_zero = (addr[AW-1:5] == '0);
  assign mode_cap     = wr_start && !zz_n && cap_ok && addr_hi_zero;
  assign arr_wr       = wr_start && zz_n && awake;
  assign idle_st      = act_cond ? ST_ACT : ST_STBY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      zz_prev <= 1'b1;
    end else begin
      wr_prev <= wr_cond;
      zz_prev <= zz_n;
    end
  end

  // Power state sequencing
  always_comb begin
    state_nx = state;
    case (state)
      ST_PWRUP:         if (tcount >= T_PWR) state_nx = ST_STBY;
      ST_STBY, ST_ACT:  if (!zz_n) state_nx = mode_cap ? ST_REGWR : ST_ZZWAIT;
                        else       state_nx = idle_st;
      ST_ZZWAIT: begin
        if (zz_n)                  state_nx = idle_st;
        else if (mode_cap)         state_nx = ST_REGWR;
        else if (tcount >= T_WIN)  state_nx = mode.dpd_off ? ST_SLEEP : ST_DPD;
      end
      ST_REGWR:         if (zz_n) state_nx = idle_st;
      ST_SLEEP:         if (zz_n && tcount >= T_RES) state_nx = idle_st;
      ST_DPD:           if (zz_n && tcount >= T_RES) state_nx = ST_RECOV;
      ST_RECOV:         if (tcount >= T_REC) state_nx = idle_st;
      default:          state_nx = ST_PWRUP;
    endcase
  end

  assign tmr_clr = (state_nx != state) || ((state == ST_PWRUP) && !(cs_n && zz_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_PWRUP;
      data_valid <= 1'b0;
    end else begin
      state <= state_nx;
      if (state_nx == ST_DPD && state != ST_DPD) data_valid <= 1'b0;
      else if (arr_wr)                            data_valid <= 1'b1;
    end
  end

  lpm_timer #(.W(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (us_tick),
    .count (tcount)
  );

  lpm_modereg u_modereg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (mode_cap),
    .cap_val  (lpm_mode_t'(addr[4:0])),
    .zz_rise  (zz_rise),
    .mode     (mode),
    .rsvd_err (rsvd_err)
  );

  lpm_window #(.AW(AW)) u_window (
    .mode  (mode),
    .base  (win_base),
    .limit (win_limit)
  );

  assign pstate = state;
  assign ready  = awake;

  // R1: standby is reached only after the full power-up wait
  a_r1_pwrup_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STBY && $past(state) == ST_PWRUP) |-> $past(tcount) >= T_PWR);

  // R7: low-power residency honoured before any exit
  a_r7_residency: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state) == ST_SLEEP || $past(state) == ST_DPD) && state != $past(state))
      |-> $past(tcount) >= T_RES);

  // R8: contents never claimed valid while recovering
  a_r8_recov_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV) |-> !data_valid);

endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, we_n, lb_n, ub_n, zz_n, us_tick;
  logic [19:0] addr;
  logic [2:0]  pstate;
  logic        ready, data_valid, rsvd_err;
  logic [19:0] win_base, win_limit;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  string       tq[$];
  int          sq[$];
  logic [19:0] eq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n),
    .zz_n(zz_n), .addr(addr), .us_tick(us_tick), .pstate(pstate), .ready(ready),
    .data_valid(data_valid), .win_base(win_base), .win_limit(win_limit), .rsvd_err(rsvd_err)
  );

  function automatic logic [19:0] actual(int s);
    case (s)
      0: return {17'd0, pstate};
      1: return {19'd0, ready};
      2: return {19'd0, data_valid};
      3: return win_base;
      4: return win_limit;
      default: return {19'd0, rsvd_err};
    endcase
  endfunction

  // Monitor: pops expectations and compares just after the falling edge
  always @(negedge clk) begin
    #1;
    while (tq.size() > 0) begin
      string t; int s; logic [19:0] e; logic [19:0] a;
      t = tq.pop_front(); s = sq.pop_front(); e = eq.pop_front();
      a = actual(s);
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", t, s, a, e);
      end
    end
  end

  task automatic expect_item(string tag, int sel, logic [19:0] val);
    tq.push_back(tag); sq.push_back(sel); eq.push_back(val);
  endtask

  // Window restated from the size of each area
  task automatic expect_win(string tag, logic [4:0] code);
    int size, base;
    size = (code[1:0] == 2'b10) ? 'h80000 : (code[1:0] == 2'b11) ? 'h40000 : 'h100000;
    base = code[2] ? ('h100000 - size) : 0;
    expect_item(tag, 3, base[19:0]);
    expect_item(tag, 4, 20'(base + size - 1));
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      us_tick = 1'b1; @(negedge clk);
      us_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wr_release();
    cs_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
  endtask

  // Register load through the entry-wait path
  task automatic load_mode(logic [4:0] code);
    zz_n = 1'b0; cyc(1);
    expect_item("R6 entry wait", 0, 20'd3);
    addr = {15'd0, code}; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; cyc(1);
    expect_item("R6 register write state", 0, 20'd4);
    wr_release(); cyc(1);
    zz_n = 1'b1; cyc(1);
    expect_item("R2 standby after load", 0, 20'd1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    zz_n = 1'b1; addr = '0; us_tick = 1'b0;
    cyc(3); rst_n = 1'b1; cyc(1);
    expect_item("R1 reset state", 0, 20'd0);
    expect_item("R1 reset ready", 1, 20'd0);
    expect_item("R1 reset data_valid", 2, 20'd0);
    expect_item("R10 no error at reset", 5, 20'd0);
    expect_win("R4 default window", 5'b10000);

    // R1: interrupted power-up wait restarts
    ticks(100); zz_n = 1'b0; cyc(1); zz_n = 1'b1; cyc(1);
    ticks(149); cyc(1);
    expect_item("R1 still waiting", 0, 20'd0);
    ticks(1);
    expect_item("R1 standby reached", 0, 20'd1);
    expect_item("R2 ready in standby", 1, 20'd1);

    // R2 / R11: active state and array write
    cs_n = 1'b0; lb_n = 1'b0; cyc(1);
    expect_item("R2 active", 0, 20'd2);
    expect_item("R11 no write yet", 2, 20'd0);
    we_n = 1'b0; cyc(1);
    expect_item("R11 write sets valid", 2, 20'd1);
    we_n = 1'b1; lb_n = 1'b1; cyc(1);
    expect_item("R2 byte enables high gives standby", 0, 20'd1);
    cs_n = 1'b1; cyc(1);

    // R3 / R5: quarter bottom, staged until the rise
    zz_n = 1'b0; cyc(1);
    addr = 20'h00013; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; cyc(1);
    expect_item("R6 capture moves to register write", 0, 20'd4);
    expect_win("R3 window unchanged before rise", 5'b10000);
    wr_release(); cyc(1);
    zz_n = 1'b1; cyc(1);
    expect_win("R5 quarter bottom", 5'b10011);

    // R6 / R7 / R9: sleep, residency, revert of partial mode
    zz_n = 1'b0; cyc(1);
    expect_item("R6 entry wait", 0, 20'd3);
    ticks(1);
    expect_item("R6 sleep entered", 0, 20'd5);
    expect_item("R2 not ready in sleep", 1, 20'd0);
    addr = 20'h0001F; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; cyc(1);
    wr_release(); cyc(1);
    zz_n = 1'b1; ticks(9);
    expect_item("R7 held in sleep", 0, 20'd5);
    expect_win("R9 partial reverts to default", 5'b10000);
    ticks(1);
    expect_item("R7 sleep left", 0, 20'd1);
    expect_item("R11 valid kept over sleep", 2, 20'd1);
    zz_n = 1'b0; cyc(1); zz_n = 1'b1; cyc(1);
    expect_item("R6 early rise returns to standby", 0, 20'd1);
    expect_win("R3 write in sleep ignored", 5'b10000);

    // R5: remaining windows
    load_mode(5'b10010); expect_win("R5 half bottom", 5'b10010);
    load_mode(5'b10111); expect_win("R5 quarter top", 5'b10111);

    // Capture on the same edge as the fall
    zz_n = 1'b0; addr = 20'h0001E; cs_n = 1'b0; we_n = 1'b0; ub_n = 1'b0; cyc(1);
    expect_item("R6 capture at fall", 0, 20'd4);
    wr_release(); cyc(1); zz_n = 1'b1; cyc(1);
    expect_win("R5 half top", 5'b11110);
    zz_n = 1'b0; cyc(1); zz_n = 1'b1; cyc(1);
    expect_win("R9 reduced size kept", 5'b11110);

    // R3: nonzero upper address ignored
    zz_n = 1'b0; cyc(1);
    addr = 20'h80013; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; cyc(1);
    expect_item("R3 upper bits nonzero ignored", 0, 20'd3);
    wr_release(); zz_n = 1'b1; cyc(1);
    expect_win("R3 window kept", 5'b11110);

    // R10 / R4: reserved code, deep power down armed
    zz_n = 1'b0; addr = 20'h00001; cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; cyc(1);
    expect_item("R10 error pulse", 5, 20'd1);
    wr_release(); cyc(1);
    expect_item("R10 pulse one cycle", 5, 20'd0);
    zz_n = 1'b1; cyc(1);
    expect_win("R4 reserved decodes full", 5'b00000);

    // R6 / R8 / R11: deep power down and recovery
    zz_n = 1'b0; cyc(1);
    ticks(1);
    expect_item("R6 deep power down", 0, 20'd6);
    expect_item("R11 valid cleared", 2, 20'd0);
    zz_n = 1'b1; ticks(9);
    expect_item("R7 held in deep power down", 0, 20'd6);
    ticks(1);
    expect_item("R8 recovery", 0, 20'd7);
    expect_item("R8 not ready", 1, 20'd0);
    ticks(149);
    expect_item("R8 still recovering", 0, 20'd7);
    expect_item("R8 data invalid", 2, 20'd0);
    ticks(1);
    expect_item("R8 back to standby", 0, 20'd1);
    expect_item("R8 ready again", 1, 20'd1);
    expect_win("R9 default after wake", 5'b10000);

    // R9: deep power down disarmed after wake
    zz_n = 1'b0; cyc(1); ticks(1);
    expect_item("R9 dpd disarmed, plain sleep", 0, 20'd5);
    zz_n = 1'b1; ticks(10);
    expect_item("R7 sleep left again", 0, 20'd1);

    cyc(2);
    done = 1;
    summary();
    $finish;
  end
endmodule